// File: doc/BRIEF.md
# Prescaled Timebase Counter with Edge Capture

This block produces a steady time reference from the system clock and timestamps events on an external pin. A prescaler divides the clock by 32. Each prescaled tick advances an 8-bit counter that counts 0 through 249 and then returns to 0. Each return to zero can raise a timebase flag. A control bit can stretch the flag interval to two full counter periods.

An external capture pin passes through a two-stage synchronizer. On the chosen edge, rising or falling, the counter value is copied into a capture register and a capture flag is raised. No new capture is taken while that flag is pending. Software reaches the block through a single-cycle read/write port with one select line. Select 0 addresses the control/status register and select 1 addresses the capture register. Each flag clears when its register is read. Each flag drives its own interrupt line through an enable bit. The counter itself cannot be read or written.

Top module: `tbc_timer`

## Requirements
- R1: After reset, the control/status register reads 0x00, the capture register reads 0x00, and both interrupt lines are low.
- R2: The counter starts at 0, advances once every 32 clock cycles and wraps from 249 to 0. With period doubling off, the timebase flag first becomes set at the 8000th rising clock edge after reset release.
- R3: With the doubling bit (control bit 1) set, the flag is set only on every second wrap, so the first flag appears at edge 16000 and not at edge 8000.
- R4: A read with select 0 returns the status byte {tb_flag(bit 7), cap_flag(bit 6), 00, control bits 3:0} as it was before the read, and clears the timebase flag at the end of that cycle.
- R5: When a wrap that sets the timebase flag falls in the same cycle as a status read, the flag is set after that cycle.
- R6: irq_tb is high exactly when the timebase flag and the timebase enable (control bit 0) are both set.
- R7: A pin transition is captured after two synchronizer stages. The capture register takes the counter value held in the cycle before the third rising edge after the pin changes, and the capture flag becomes set at that edge.
- R8: Control bit 3 selects the capture edge: 1 means rising and 0 means falling. The other edge causes no capture.
- R9: While the capture flag is set, further edges do not change the capture register. A read with select 1 returns the captured value and clears the capture flag, and the value remains readable afterwards.
- R10: irq_cap is high exactly when the capture flag and the capture enable (control bit 2) are both set.
- R11: Writes with select 1 have no effect. Status bits 7:4 ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control/status, 1 capture |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| cap_pin | input | 1 | Asynchronous capture input |
| irq_tb | output | 1 | Timebase interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
Two actions can fall in the same cycle: the counter wrap that sets the timebase flag, and a status read that clears it. The bench runs a model of the counter from reset release. It places the read strobe exactly in the cycle before edge 8000. After that edge it expects the interrupt line to stay high, and it expects a later read to still report the flag. A second overlap, a capture edge that arrives while the capture flag is pending, is judged by reading back the first captured value.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
    typedef struct packed {
        logic cap_rise;
        logic cap_ie;
        logic dbl;
        logic tb_ie;
    } tbc_ctrl_t;

    localparam int unsigned CTRL_W    = 4;
    localparam int unsigned STAT_CAPF = 6;
    localparam int unsigned STAT_TBF  = 7;
endpackage

// File: rtl/tbc_prescaler.sv
module tbc_prescaler #(
    parameter int unsigned PRE_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRE_DIV <= 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PRE_W = $clog2(PRE_DIV);
            localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

            logic [PRE_W-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = (pre_q == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R2
        end
    endgenerate
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned CNT_TOP = 249
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dbl,
    output logic [CNT_W-1:0] cnt,
    output logic             evt
);
    localparam logic [CNT_W-1:0] TOP_V = CNT_W'(CNT_TOP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d = st_q;
        wrap = tick && (st_q.cnt == TOP_V);
        if (tick) st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        if (!dbl)      st_d.half = 1'b0;
        else if (wrap) st_d.half = ~st_q.half;
        evt = wrap && (!dbl || st_q.half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP_V); // R2
    AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.cnt)); // R2
    AST_DBL_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl && evt) |=> !st_q.half); // R3
endmodule

// File: rtl/tbc_edge_sync.sv
module tbc_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES:0] sh_d, sh_q;
    logic                 now_v, old_v;

    always_comb begin
        sh_d     = {sh_q[SYNC_STAGES-1:0], pin};
        now_v    = sh_q[SYNC_STAGES-1];
        old_v    = sh_q[SYNC_STAGES];
        edge_hit = rise_sel ? (now_v && !old_v) : (!now_v && old_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tbc_timer.sv
module tbc_timer
    import tbc_pkg::*;
#(
    parameter int unsigned PRE_DIV     = 32,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned CNT_TOP     = 249,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cap_pin,
    output logic       irq_tb,
    output logic       irq_cap
);
    typedef struct packed {
        tbc_ctrl_t        ctrl;
        logic             tb_f;
        logic             cap_f;
        logic [CNT_W-1:0] cap_v;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic             tick, tb_evt, edge_hit;
    logic             rd_stat, rd_cap, cap_take;
    logic [CNT_W-1:0] cnt;

    tbc_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    tbc_timebase #(.CNT_W(CNT_W), .CNT_TOP(CNT_TOP)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(s_q.ctrl.dbl),
        .cnt(cnt), .evt(tb_evt)
    );

    tbc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin),
        .rise_sel(s_q.ctrl.cap_rise), .edge_hit(edge_hit)
    );

    always_comb begin
        s_d      = s_q;
        rd_stat  = reg_rd && !reg_sel;
        rd_cap   = reg_rd && reg_sel;
        cap_take = edge_hit && !s_q.cap_f;

        if (reg_wr && !reg_sel) s_d.ctrl = tbc_ctrl_t'(reg_wdata[CTRL_W-1:0]);

        if (rd_stat) s_d.tb_f = 1'b0;
        if (tb_evt)  s_d.tb_f = 1'b1;

        if (rd_cap) s_d.cap_f = 1'b0;
        if (cap_take) begin
            s_d.cap_f = 1'b1;
            s_d.cap_v = cnt;
        end

        if (reg_sel) begin
            reg_rdata = 8'(s_q.cap_v);
        end else begin
            reg_rdata                = 8'(s_q.ctrl);
            reg_rdata[STAT_TBF]      = s_q.tb_f;
            reg_rdata[STAT_CAPF]     = s_q.cap_f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_tb  = s_q.tb_f  && s_q.ctrl.tb_ie;
    assign irq_cap = s_q.cap_f && s_q.ctrl.cap_ie;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tb_evt |=> s_q.tb_f); // R5
    AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !tb_evt) |=> !s_q.tb_f); // R4
    AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cap_f |=> $stable(s_q.cap_v)); // R9
    AST_CAP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && s_q.cap_f) |=> !s_q.cap_f); // R9
    AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cap_f) |-> $past(edge_hit)); // R7
endmodule

// File: tb/tb_tbc_timer.sv
`timescale 1ns/1ps
module tb_tbc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cap_pin = 1'b0;
    logic       irq_tb, irq_cap;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int       cyc;
    int       m_pre;
    int       m_cnt;

    always #10 clk = ~clk;

    tbc_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cap_pin(cap_pin), .irq_tb(irq_tb), .irq_cap(irq_cap)
    );

    // independent counter model built from the requirements (R2)
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 0; m_pre <= 0; m_cnt <= 0;
        end else begin
            cyc <= cyc + 1;
            if (m_pre == 31) begin
                m_pre <= 0;
                m_cnt <= (m_cnt == 249) ? 0 : m_cnt + 1;
            end else begin
                m_pre <= m_pre + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        reg_rd = 0; reg_wr = 0; reg_sel = 0; cap_pin = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic rd(input logic sel, output logic [7:0] data);
        reg_sel = sel; reg_rd = 1;
        #1 data = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1;
        @(posedge clk); #1;
        reg_wr = 0;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) begin @(posedge clk); #1; end
    endtask

    // change the pin now; returns the counter value the capture should hold (R7)
    task automatic pin_to(input logic v, output int exp_v);
        cap_pin = v;
        @(posedge clk);
        @(posedge clk); #1;
        exp_v = m_cnt;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 irq_tb", irq_tb, 0);
        chk("R1 irq_cap", irq_cap, 0);
        rd(1'b0, d); chk("R1 status", d, 8'h00);
        rd(1'b1, d); chk("R1 capture", d, 8'h00);
    endtask

    task automatic t_period_and_overlap();
        logic [7:0] d;
        do_reset();
        wr(1'b0, 8'h01);
        wait_cyc(7999);
        chk("R2 no flag before edge 8000", irq_tb, 0);
        reg_sel = 0; reg_rd = 1;               // read in the wrap cycle
        @(posedge clk); #1; reg_rd = 0;
        chk("R5 set wins over read", irq_tb, 1);
        chk("R2 flag at edge 8000", cyc, 8000);
        rd(1'b0, d);
        chk("R4 status shows flag", d, 8'h81);
        chk("R4 read cleared flag", irq_tb, 0);
        wr(1'b0, 8'h00);
        wait_cyc(16001);
        chk("R6 flag set but enable off", irq_tb, 0);
        wr(1'b0, 8'h01);
        chk("R6 enable exposes flag", irq_tb, 1);
        rd(1'b0, d);
        chk("R4 second flag seen", d[7], 1);
    endtask

    task automatic t_double();
        do_reset();
        wr(1'b0, 8'h03);
        wait_cyc(8001);
        chk("R3 no flag at first wrap", irq_tb, 0);
        wait_cyc(15999);
        chk("R3 no flag before edge 16000", irq_tb, 0);
        @(posedge clk); #1;
        chk("R3 flag at edge 16000", irq_tb, 1);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        int e1, e2, e3;
        do_reset();
        wr(1'b0, 8'h0C);
        wait_cyc(1000);
        pin_to(1'b1, e1);
        chk("R10 irq_cap after capture", irq_cap, 1);
        wait_cyc(1500);
        pin_to(1'b0, e2);
        wait_cyc(2000);
        pin_to(1'b1, e2);                        // edge while flag pending
        repeat (5) @(posedge clk); #1;
        rd(1'b1, d);
        chk("R9 inhibited capture keeps first value", d, e1);
        chk("R7 captured value matches counter", d, 8'd31);
        chk("R9 read clears capture flag", irq_cap, 0);
        rd(1'b1, d);
        chk("R9 value kept after read", d, e1);
        wr(1'b1, 8'hAA);
        rd(1'b1, d);
        chk("R11 capture write ignored", d, e1);
        wr(1'b0, 8'hF4);                         // falling edge, cap_ie on
        rd(1'b0, d);
        chk("R11 status upper bits ignore writes", d, 8'h04);
        pin_to(1'b0, e3);
        rd(1'b1, d);
        chk("R8 falling edge captures", d, e3);
        pin_to(1'b1, e2);
        repeat (4) @(posedge clk); #1;
        chk("R8 rising edge ignored in falling mode", irq_cap, 0);
        rd(1'b1, d);
        chk("R8 capture unchanged by rising edge", d, e3);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period_and_overlap();
        t_double();
        t_capture();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule